// File: doc/BRIEF.md
# Masked interrupt flag controller

This block gathers seven single-cycle event pulses into sticky status flags and combines them into one interrupt line. A mask register selects which flags may reach the interrupt. A control field selects the electrical form of that line: an active-high level, an active-low level, or a one-cycle pulse of either polarity. Software reaches the flags, the mask and the control register through a small byte-wide register port. Flags are cleared by writing ones to them.

Event detection happens upstream. Each event input is a one-cycle pulse. The controller latches it, and an event always wins over a clear aimed at the same flag in the same cycle, so no event is lost. Reads are strobed. The requested register is captured at the clock edge where the read strobe is seen, so a flag read always shows the live flag state at that edge.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A high `evt_i[i]` at a clock edge sets flag i, and the flag stays set until it is cleared. Flag positions: 6 short-circuit clear, 5 jack change, 4 short-circuit, 3 ramp-up done, 2 ramp-down done, 1 gain-up done, 0 gain-down done.
- R2: A write to address 0 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R3: If an event and a clear hit the same flag at the same edge, the flag is set after that edge.
- R4: The mask register is at address 1. It can be read and written, and it resets to 0xFF. A 1 in bit i stops flag i from reaching the interrupt.
- R5: The control register is at address 2. It resets to 0x00, and bits 7:6 select the output form: 0 active-high level, 1 active-low level, 2 active-high pulse, 3 active-low pulse.
- R6: In form 0, `irq_o` is 1 exactly while some flag is set and its mask bit is 0.
- R7: In form 1, `irq_o` is the inverse of the form-0 condition.
- R8: In form 2, `irq_o` is 1 for exactly the first cycle in which a flag shows newly set while its mask bit is 0. A flag that was already set, that is masked, or that is unmasked later gives no pulse.
- R9: In form 3, `irq_o` is the inverse of the form-2 pulse.
- R10: When `reg_rd` is high at an edge, `reg_rdata` takes the register at `reg_addr` as it was just before that edge, and holds it until the next read. The flag read has bit 7 at 0. Address 3 reads 0, and writes to it have no effect.
- R11: After reset, all flags are 0, `reg_rdata` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 7 | One-cycle event pulses, one per flag |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Captured read data |
| irq_o | output | 1 | Interrupt output in the selected form |

## Verification
Two situations are hard to reach from the ports. The first is an event landing on the same edge as a write-one clear of that same flag. The second is a flag being unmasked while it is already set, which must not produce a pulse in the pulse forms. Directed steps create both on purpose. After that, sparse random event pulses run together with random writes to every address, so the same collisions and mask changes recur in all four output forms. A cycle-by-cycle reference model checks the interrupt line and the read data against each of these cases.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

  localparam logic [DATA_W-1:0] MASK_RST = 8'hFF;
  localparam logic [DATA_W-1:0] CTRL_RST = 8'h00;

  typedef enum logic [1:0] {
    FORM_LVL_HI   = 2'd0,
    FORM_LVL_LO   = 2'd1,
    FORM_PULSE_HI = 2'd2,
    FORM_PULSE_LO = 2'd3
  } irq_form_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NSRC = irq_pkg::NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] rise
);
  logic [NSRC-1:0] prev_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic flag_q;
    // an event outranks a clear aimed at the same bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (evt[i]) begin
        flag_q <= 1'b1;
      end else if (clr[i]) begin
        flag_q <= 1'b0;
      end
    end
    assign flags[i] = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= flags;
    end
  end

  assign rise = flags & ~prev_q;
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file #(
  parameter int unsigned DW   = irq_pkg::DATA_W,
  parameter int unsigned AW   = irq_pkg::ADDR_W,
  parameter int unsigned NSRC = irq_pkg::NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] clr,
  output logic [DW-1:0]   mask,
  output logic [DW-1:0]   ctrl,
  output logic [DW-1:0]   rdata
);
  import irq_pkg::*;

  localparam int unsigned PAD_W = DW - NSRC;

  logic [DW-1:0] mask_q, ctrl_q, rdata_q, rd_mux;
  logic          wr_flag, wr_mask, wr_ctrl;

  assign wr_flag = wr && (addr == ADDR_FLAG);
  assign wr_mask = wr && (addr == ADDR_MASK);
  assign wr_ctrl = wr && (addr == ADDR_CTRL);

  assign clr = wr_flag ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      ctrl_q <= CTRL_RST;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_FLAG: rd_mux = {{PAD_W{1'b0}}, flags};
      ADDR_MASK: rd_mux = mask_q;
      ADDR_CTRL: rd_mux = ctrl_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign mask  = mask_q;
  assign ctrl  = ctrl_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int unsigned NSRC = irq_pkg::NUM_SRC
) (
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] rise,
  input  logic [NSRC-1:0] mask,
  input  logic [1:0]      form,
  output logic            irq
);
  import irq_pkg::*;

  logic      pending, fresh;
  irq_form_e form_e;

  assign pending = |(flags & ~mask);
  assign fresh   = |(rise & ~mask);
  assign form_e  = irq_form_e'(form);

  always_comb begin
    unique case (form_e)
      FORM_LVL_HI:   irq = pending;
      FORM_LVL_LO:   irq = ~pending;
      FORM_PULSE_HI: irq = fresh;
      FORM_PULSE_LO: irq = ~fresh;
      default:       irq = pending;
    endcase
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int unsigned NSRC = irq_pkg::NUM_SRC,
  parameter int unsigned DW   = irq_pkg::DATA_W,
  parameter int unsigned AW   = irq_pkg::ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            reg_wr,
  input  logic            reg_rd,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_o
);
  localparam int unsigned FORM_HI = DW - 1;
  localparam int unsigned FORM_LO = DW - 2;

  logic [NSRC-1:0] clr_vec, flag_vec, rise_vec;
  logic [DW-1:0]   mask_reg, ctrl_reg;

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_i),
    .clr   (clr_vec),
    .flags (flag_vec),
    .rise  (rise_vec)
  );

  irq_reg_file #(.DW(DW), .AW(AW), .NSRC(NSRC)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .flags (flag_vec),
    .clr   (clr_vec),
    .mask  (mask_reg),
    .ctrl  (ctrl_reg),
    .rdata (reg_rdata)
  );

  irq_out_gen #(.NSRC(NSRC)) u_out (
    .flags (flag_vec),
    .rise  (rise_vec),
    .mask  (mask_reg[NSRC-1:0]),
    .form  (ctrl_reg[FORM_HI:FORM_LO]),
    .irq   (irq_o)
  );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] evt_i,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_wr,
  input logic       irq_o,
  input logic [6:0] flags,
  input logic [7:0] mask,
  input logic [7:0] ctrl
);
  // R1
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags & $past(evt_i)) == $past(evt_i)));

  // R1
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((flags & ~$past(flags) & ~$past(evt_i)) == 7'd0));

  // R2
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=>
      ((flags & $past(reg_wdata[6:0]) & ~$past(evt_i)) == 7'd0));

  // R3
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && |(evt_i & reg_wdata[6:0])) |=>
      ((flags & $past(evt_i)) == $past(evt_i)));

  // R4
  mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask == 8'hFF));

  // R6
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7:6] == 2'd0 && (&mask[6:0])) |-> !irq_o);

  // R8
  pulse_needs_new_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7:6] == 2'd2 && irq_o) |-> (flags != $past(flags)));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_wr    (reg_wr),
  .irq_o     (irq_o),
  .flags     (flag_vec),
  .mask      (mask_reg),
  .ctrl      (ctrl_reg)
);

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt_i = '0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;

  logic [6:0] m_flag, m_prev;
  logic [7:0] m_mask, m_ctl, m_rdata;

  always #4 clk = ~clk;

  irq_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_irq();
    logic pend, fresh;
    pend  = |(m_flag & ~m_mask[6:0]);
    fresh = |(m_flag & ~m_prev & ~m_mask[6:0]);
    case (m_ctl[7:6])
      2'd0: return pend;
      2'd1: return ~pend;
      2'd2: return fresh;
      default: return ~fresh;
    endcase
  endfunction

  function automatic string form_tag();
    case (m_ctl[7:6])
      2'd0: return "R6";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_flag};
      2'd1: return m_mask;
      2'd2: return m_ctl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cycle(input logic [6:0] e, input logic w, input logic r,
                       input logic [1:0] a, input logic [7:0] d);
    logic [6:0] clr;
    @(negedge clk);
    evt_i = e; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (r) m_rdata = model_read(a);
    clr = (w && a == 2'd0) ? d[6:0] : 7'd0;
    m_prev = m_flag;
    m_flag = e | (m_flag & ~clr);
    if (w && a == 2'd1) m_mask = d;
    if (w && a == 2'd2) m_ctl = d;
    #1;
    check(form_tag(), {7'd0, irq_o}, {7'd0, exp_irq()});
    check("R10", reg_rdata, m_rdata);
  endtask

  task automatic idle();
    cycle(7'd0, 1'b0, 1'b0, 2'd0, 8'd0);
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    m_flag = '0; m_prev = '0; m_mask = 8'hFF; m_ctl = 8'h00; m_rdata = 8'h00;
    void'($urandom(32'h5EED_1234));
    #20;
    // R11 reset state
    check("R11", reg_rdata, 8'h00);
    check("R11", {7'd0, irq_o}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R4 R5 reset values through the read port
    cycle(7'd0, 1'b0, 1'b1, 2'd1, 8'd0); idle();
    check("R4", reg_rdata, 8'hFF);
    cycle(7'd0, 1'b0, 1'b1, 2'd2, 8'd0); idle();
    check("R5", reg_rdata, 8'h00);

    // R1 masked event sets flag, no interrupt
    cycle(7'h20, 1'b0, 1'b0, 2'd0, 8'd0);
    check("R4", {7'd0, irq_o}, 8'h00);
    cycle(7'd0, 1'b0, 1'b1, 2'd0, 8'd0); idle();
    check("R1", reg_rdata, 8'h20);
    // unmask: level rises
    cycle(7'd0, 1'b1, 1'b0, 2'd1, 8'h00);
    check("R6", {7'd0, irq_o}, 8'h01);
    // R2 writing zeros keeps flag
    cycle(7'd0, 1'b1, 1'b0, 2'd0, 8'h00);
    cycle(7'd0, 1'b0, 1'b1, 2'd0, 8'd0); idle();
    check("R2", reg_rdata, 8'h20);
    // R2 write one clears
    cycle(7'd0, 1'b1, 1'b0, 2'd0, 8'hFF);
    check("R2", {7'd0, irq_o}, 8'h00);
    // R3 event and clear of same bit at same edge
    cycle(7'h08, 1'b1, 1'b0, 2'd0, 8'h08);
    cycle(7'd0, 1'b0, 1'b1, 2'd0, 8'd0); idle();
    check("R3", reg_rdata, 8'h08);
    // R7 active-low level
    cycle(7'd0, 1'b1, 1'b0, 2'd2, 8'h40);
    check("R7", {7'd0, irq_o}, 8'h00);
    cycle(7'd0, 1'b1, 1'b0, 2'd0, 8'h7F);
    check("R7", {7'd0, irq_o}, 8'h01);
    // R8 pulse form: one cycle only
    cycle(7'd0, 1'b1, 1'b0, 2'd2, 8'h80);
    cycle(7'h01, 1'b0, 1'b0, 2'd0, 8'd0);
    check("R8", {7'd0, irq_o}, 8'h01);
    idle();
    check("R8", {7'd0, irq_o}, 8'h00);
    // R8 re-event on set flag: no pulse
    cycle(7'h01, 1'b0, 1'b0, 2'd0, 8'd0);
    check("R8", {7'd0, irq_o}, 8'h00);
    // R8 masked set then unmask: no pulse
    cycle(7'd0, 1'b1, 1'b0, 2'd1, 8'h04);
    cycle(7'h04, 1'b0, 1'b0, 2'd0, 8'd0);
    check("R8", {7'd0, irq_o}, 8'h00);
    cycle(7'd0, 1'b1, 1'b0, 2'd1, 8'h00);
    check("R8", {7'd0, irq_o}, 8'h00);
    // R9 low pulse
    cycle(7'd0, 1'b1, 1'b0, 2'd2, 8'hC0);
    cycle(7'd0, 1'b1, 1'b0, 2'd0, 8'h7F);
    cycle(7'h10, 1'b0, 1'b0, 2'd0, 8'd0);
    check("R9", {7'd0, irq_o}, 8'h00);
    idle();
    check("R9", {7'd0, irq_o}, 8'h01);
    // R10 address 3: write ignored, reads zero
    cycle(7'd0, 1'b1, 1'b0, 2'd3, 8'hA5);
    cycle(7'd0, 1'b0, 1'b1, 2'd3, 8'd0); idle();
    check("R10", reg_rdata, 8'h00);
    cycle(7'd0, 1'b0, 1'b1, 2'd1, 8'd0); idle();
    check("R10", reg_rdata, 8'h00);
    cycle(7'd0, 1'b0, 1'b1, 2'd2, 8'd0); idle();
    check("R10", reg_rdata, 8'hC0);

    // constrained random per output form
    for (int f = 0; f < 4; f++) begin
      cycle(7'd0, 1'b1, 1'b0, 2'd2, {f[1:0], 6'd0});
      for (int n = 0; n < 1500; n++) begin
        logic [6:0] e;
        logic [7:0] d;
        logic [1:0] a;
        for (int b = 0; b < 7; b++) e[b] = ($urandom % 8) == 0;
        a = 2'($urandom % 4);
        d = 8'($urandom);
        if (a == 2'd2) d[7:6] = f[1:0];
        cycle(e, ($urandom % 4) == 0, ($urandom % 3) == 0, a, d);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule